// File: doc/BRIEF.md
# Nibble-Table Constant Multiplier

This block multiplies an 8-bit sample by a fixed 8-bit coefficient without an array multiplier. The sample is cut into a low nibble and a high nibble. Each nibble indexes its own 16-entry table of precomputed 12-bit partial products. The two table outputs are merged by one add, in which the high partial product carries a weight of 16. The result is a 16-bit product. Both table reads and the add are registered. A result therefore leaves the block two clocks after its sample was accepted, and a valid strobe follows the same path.

The tables sit in writable storage, so a load port can swap in a new coefficient without stopping the sample stream. The block does not compute table contents itself; whoever drives the load port writes coefficient × k into entry k of both tables. Two parameters select variants. `WRITABLE = 0` turns the tables into constants derived from the `COEF` parameter, and the load inputs are then ignored. `SIGNED_MODE = 1` treats sample and coefficient as two's complement. In that mode the high table holds coefficient × (signed nibble), and the low partial product is sign-extended before the add.

Top module: `nibble_lut_mult`

## Requirements
- R1: With entry k of both tables holding (C·k) mod 4096 for a coefficient C, a valid sample S yields product = C·S (unsigned, default parameters). Sample bits [3:0] index the low table and bits [7:4] index the high table.
- R2: When `tbl_we` is high at a rising clock edge, `tbl_wdata` is stored at entry `tbl_addr`. The low table is written when `tbl_sel` = 0 and the high table when `tbl_sel` = 1; the other table is unchanged.
- R3: For arbitrary table contents L[] and H[], the product equals (16·H[S[7:4]] + L[S[3:0]]) mod 65536.
- R4: `out_valid` is high exactly two rising edges after a rising edge at which `in_valid` was high. A new sample may be accepted on every clock.
- R5: A table write made in the same cycle a sample is accepted does not affect that sample's product. It does affect samples accepted in later cycles.
- R6: Boundary operands give exact products with no overflow: 0·x = 0, 255·255 = 65025, and 255·0x0F and 255·0xF0 are exact.
- R7: While `rst_n` is low at a rising edge, the next cycle shows `out_valid` = 0 and `product` = 0.
- R8: `product` holds its last value while `out_valid` is low. Samples presented with `in_valid` low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Multiplicand sample |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | Table select: 0 low nibble table, 1 high nibble table |
| tbl_addr | input | 4 | Table entry index |
| tbl_wdata | input | 12 | Partial product to store |
| out_valid | output | 1 | Product strobe |
| product | output | 16 | Registered product |

## Verification
The assertions assume that `in_sample` is free of unknowns whenever `in_valid` is high, and that the write address and select are known whenever `tbl_we` is high. They also assume that every table entry a valid sample can reach has been written before that sample arrives; otherwise an unknown product would be legitimate. The stimulus meets these assumptions. It fills all 32 entries through the load port before the first valid sample, and it drives every input to a known value on every cycle, including idle ones. Idle cycles carry nonzero garbage samples so that the bench can see whether they leak into the output.

// File: rtl/nlm_pkg.sv
// Package: shared types and the constant-table entry function for the
// nibble-table multiplier. Assumes data widths of at most 16 bits.
package nlm_pkg;

    // Table selector encoding used on the load port.
    typedef enum logic {
        TBL_LOW  = 1'b0,
        TBL_HIGH = 1'b1
    } tbl_id_e;

    // Partial product for entry k of one table, used only by the constant
    // (read-only) variant. In signed mode the coefficient is two's complement,
    // and the high table treats its index as a signed nibble.
    function automatic int table_entry(input int coef, input int k,
                                       input int data_w, input bit is_high,
                                       input bit signed_mode);
        int c;
        int idx;
        int nib_w;
        nib_w = data_w / 2;
        c     = coef;
        idx   = k;
        if (signed_mode && c >= (1 << (data_w - 1)))
            c = c - (1 << data_w);
        if (signed_mode && is_high && idx >= (1 << (nib_w - 1)))
            idx = idx - (1 << nib_w);
        return c * idx;
    endfunction

endpackage

// File: rtl/pp_table.sv
// Module: pp_table
// One partial-product table with a registered read port. With WRITABLE = 1
// it is a small write-first-free storage array: a write and a read at the
// same edge return the old entry. With WRITABLE = 0 the entries are
// constants computed from COEF, and the write inputs are ignored.
// Assumes the caller never reads an entry it has not written (writable form).
module pp_table #(
    parameter int DATA_W      = 8,
    parameter int NIB_W       = DATA_W / 2,
    parameter int PP_W        = DATA_W + NIB_W,
    parameter bit WRITABLE    = 1'b1,
    parameter bit SIGNED_MODE = 1'b0,
    parameter bit IS_HIGH     = 1'b0,
    parameter int COEF        = 0
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] wr_addr,
    input  logic [PP_W-1:0]  wr_data,
    input  logic [NIB_W-1:0] rd_addr,
    output logic [PP_W-1:0]  rd_data
);
    import nlm_pkg::*;

    localparam int DEPTH = 1 << NIB_W;

    generate
        if (WRITABLE) begin : g_ram
            logic [PP_W-1:0] entries [DEPTH];

            // Store a new partial product on a load-port write.
            always_ff @(posedge clk) begin
                if (wr_en)
                    entries[wr_addr] <= wr_data;
            end

            // Registered read; sees the pre-write value on a same-edge write.
            always_ff @(posedge clk) begin
                rd_data <= entries[rd_addr];
            end
        end else begin : g_rom
            logic [PP_W-1:0] consts [DEPTH];

            for (genvar k = 0; k < DEPTH; k++) begin : g_entry
                assign consts[k] = PP_W'(table_entry(COEF, k, DATA_W, IS_HIGH, SIGNED_MODE));
            end

            // Registered read of the constant table.
            always_ff @(posedge clk) begin
                rd_data <= consts[rd_addr];
            end
        end
    endgenerate

endmodule

// File: rtl/pp_combiner.sv
// Module: pp_combiner
// Merges the two partial products into the product register. The low
// NIB_W bits of the low partial product pass straight through; the rest is
// widened (zero- or sign-extended) and added to the high partial product
// with an adder that is only PROD_W - NIB_W bits wide.
// Assumes PP_W == PROD_W - NIB_W and that both inputs belong to one sample.
module pp_combiner #(
    parameter int NIB_W       = 4,
    parameter int PP_W        = 12,
    parameter int PROD_W      = 16,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pp_valid,
    input  logic [PP_W-1:0]   lo_pp,
    input  logic [PP_W-1:0]   hi_pp,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);
    localparam int UP_W  = PROD_W - NIB_W;
    localparam int TOP_W = PP_W - NIB_W;

    logic [TOP_W-1:0] lo_top;
    logic [UP_W-1:0]  lo_wide;
    logic [UP_W-1:0]  upper_sum;

    assign lo_top = lo_pp[PP_W-1:NIB_W];

    generate
        if (SIGNED_MODE) begin : g_sext
            assign lo_wide = {{(UP_W - TOP_W){lo_top[TOP_W-1]}}, lo_top};
        end else begin : g_zext
            assign lo_wide = {{(UP_W - TOP_W){1'b0}}, lo_top};
        end
    endgenerate

    // Weighted add: high partial product sits NIB_W bits above the low one.
    always_comb begin
        upper_sum = hi_pp[UP_W-1:0] + lo_wide;
    end

    // Valid strobe of the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= pp_valid;
    end

    // Product register; loads only for a valid sample, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            product <= '0;
        else if (pp_valid)
            product <= {upper_sum, lo_pp[NIB_W-1:0]};
    end

endmodule

// File: rtl/nibble_lut_mult.sv
// Module: nibble_lut_mult (top)
// Constant-coefficient multiplier built from two nibble-indexed tables of
// partial products and one weighted add. Latency is two clocks: the table
// read is registered, then the add is registered. The load port rewrites
// table entries. Assumes DATA_W is even and the tables are filled before use.
module nibble_lut_mult #(
    parameter int DATA_W      = 8,
    parameter bit SIGNED_MODE = 1'b0,
    parameter bit WRITABLE    = 1'b1,
    parameter int COEF        = 0,
    localparam int NIB_W      = DATA_W / 2,
    localparam int PP_W       = DATA_W + NIB_W,
    localparam int PROD_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [NIB_W-1:0]  tbl_addr,
    input  logic [PP_W-1:0]   tbl_wdata,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);
    import nlm_pkg::*;

    localparam int N_TBL = 2;

    logic [PP_W-1:0] pp [N_TBL];
    logic            s1_valid;

    generate
        for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
            logic             we_g;
            logic [NIB_W-1:0] idx_g;

            assign we_g  = tbl_we && (tbl_id_e'(tbl_sel) == tbl_id_e'(g));
            assign idx_g = in_sample[g*NIB_W +: NIB_W];

            pp_table #(
                .DATA_W      (DATA_W),
                .NIB_W       (NIB_W),
                .PP_W        (PP_W),
                .WRITABLE    (WRITABLE),
                .SIGNED_MODE (SIGNED_MODE),
                .IS_HIGH     (g == 1),
                .COEF        (COEF)
            ) u_table (
                .clk     (clk),
                .wr_en   (we_g),
                .wr_addr (tbl_addr),
                .wr_data (tbl_wdata),
                .rd_addr (idx_g),
                .rd_data (pp[g])
            );
        end
    endgenerate

    // Valid strobe that travels alongside the table read stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_valid <= 1'b0;
        else
            s1_valid <= in_valid;
    end

    pp_combiner #(
        .NIB_W       (NIB_W),
        .PP_W        (PP_W),
        .PROD_W      (PROD_W),
        .SIGNED_MODE (SIGNED_MODE)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pp_valid  (s1_valid),
        .lo_pp     (pp[0]),
        .hi_pp     (pp[1]),
        .out_valid (out_valid),
        .product   (product)
    );

endmodule

// File: rtl/nibble_lut_mult_chk.sv
// Module: nibble_lut_mult_chk
// Port-level property checker for nibble_lut_mult, attached by bind.
// Assumes inputs are known when their strobes are high.
module nibble_lut_mult_chk #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    parameter int PROD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              tbl_we,
    input logic              tbl_sel,
    input logic [NIB_W-1:0]  tbl_addr,
    input logic              out_valid,
    input logic [PROD_W-1:0] product
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> $stable(product));

    p_known_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(product));

    p_known_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(in_sample));

    p_known_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !$isunknown({tbl_sel, tbl_addr}));

endmodule

bind nibble_lut_mult nibble_lut_mult_chk #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W),
    .PROD_W (PROD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel),
    .tbl_addr  (tbl_addr),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/nibble_lut_mult_bench.sv
module nibble_lut_mult_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        tbl_we = 1'b0;
    logic        tbl_sel = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [11:0] tbl_wdata = '0;
    logic        out_valid;
    logic [15:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    int    lo_m [16];
    int    hi_m [16];
    bit    st0_v, st1_v;
    int    st0_p, st1_p;
    string st0_t, st1_t;
    int    last_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_lut_mult u_nibble_lut_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .out_valid(out_valid), .product(product)
    );

    task automatic check(input string tag, input logic [15:0] act_p, input logic act_v,
                         input logic [15:0] exp_p, input logic exp_v);
        checks++;
        if (act_v !== exp_v || act_p !== exp_p) begin
            errors++;
            $display("FAIL %s: out_valid=%0b product=%0d expected out_valid=%0b product=%0d",
                     tag, act_v, act_p, exp_v, exp_p);
        end
    endtask

    // One clock: check outputs due now, then drive this cycle's inputs.
    task automatic step(input bit v, input int s, input bit we, input bit sel,
                        input int a, input int d, input string tag);
        int e;
        @(negedge clk);
        if (st1_v) last_p = st1_p;
        check(st1_t, product, out_valid, 16'(last_p), st1_v);
        in_valid  = v;
        in_sample = 8'(s);
        tbl_we    = we;
        tbl_sel   = sel;
        tbl_addr  = 4'(a);
        tbl_wdata = 12'(d);
        e = (hi_m[(s >> 4) & 15] * 16 + lo_m[s & 15]) & 16'hFFFF;
        if (we) begin
            if (sel) hi_m[a & 15] = d & 12'hFFF;
            else     lo_m[a & 15] = d & 12'hFFF;
        end
        st1_v = st0_v; st1_p = st0_p; st1_t = st0_t;
        st0_v = v;     st0_p = e;     st0_t = tag;
    endtask

    task automatic load_coef(input int c, input string tag);
        for (int k = 0; k < 16; k++) step(0, 8'h5A, 1, 0, k, c * k, tag);
        for (int k = 0; k < 16; k++) step(0, 8'hA5, 1, 1, k, c * k, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'hC3, 0, 0, 0, 0, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 16; k++) begin lo_m[k] = 0; hi_m[k] = 0; end
        st0_v = 0; st1_v = 0; st0_p = 0; st1_p = 0; last_p = 0;
        st0_t = "R7"; st1_t = "R7";
        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7", product, out_valid, 16'd0, 1'b0);
        rst_n = 1'b1;

        // R2: load coefficient 183 into both tables
        load_coef(183, "R2");
        idle(2, "R8");

        // R1/R4: back-to-back sweep of every sample
        for (int s = 0; s < 256; s++) step(1, s, 0, 0, 0, 0, "R1");
        idle(3, "R4");

        // R4: isolated samples
        step(1, 8'h9E, 0, 0, 0, 0, "R4");
        idle(3, "R4");

        // R8: alternating valid and ignored garbage samples
        for (int i = 0; i < 20; i++) begin
            step(1, (i * 37 + 11) & 255, 0, 0, 0, 0, "R8");
            step(0, (i * 91 + 200) & 255, 0, 0, 0, 0, "R8");
        end
        idle(3, "R8");

        // R6: boundary operands
        load_coef(255, "R6");
        step(1, 0, 0, 0, 0, 0, "R6");
        step(1, 255, 0, 0, 0, 0, "R6");
        step(1, 8'h0F, 0, 0, 0, 0, "R6");
        step(1, 8'hF0, 0, 0, 0, 0, "R6");
        idle(3, "R6");
        load_coef(0, "R6");
        step(1, 255, 0, 0, 0, 0, "R6");
        idle(3, "R6");

        // R3: arbitrary table contents
        for (int k = 0; k < 16; k++) step(0, 0, 1, 0, k, $urandom & 12'hFFF, "R3");
        for (int k = 0; k < 16; k++) step(0, 0, 1, 1, k, $urandom & 12'hFFF, "R3");
        for (int i = 0; i < 40; i++) step(1, $urandom & 255, 0, 0, 0, 0, "R3");
        idle(3, "R3");

        // R5: write in the same cycle as a sample
        load_coef(183, "R5");
        step(1, 8'h35, 1, 0, 5, 12'hABC, "R5");
        step(1, 8'h35, 0, 0, 0, 0, "R5");
        step(1, 8'h53, 1, 1, 5, 12'h123, "R5");
        step(1, 8'h53, 0, 0, 0, 0, "R5");
        idle(4, "R5");

        summary();
    end
endmodule